// File: doc/BRIEF.md
# SONET Line BIP-8 Error Checker

This block watches a received, already descrambled STS-1 byte stream. For every frame it forms a bit-interleaved even parity over the line portion of the frame, which is everything except the 3x3 section overhead corner. It then checks that parity against the B2 byte that arrives in the frame after it. Each mismatch is added to a running error counter. The counter adds either the number of disagreeing bit positions or one per bad frame, as selected by an input.

A performance-monitor pulse copies the running count into a holding register and restarts the count. The holding register is what the surrounding monitoring logic reads. When the count passes its maximum it either stays at the top value or wraps, as selected by an input. A one-cycle error pulse marks every frame whose B2 check failed.

While the framer reports loss of frame, the block checks nothing. It waits for a fresh start-of-frame marker before it accumulates parity again.

Top module: `line_bip_monitor`

## Requirements
- R1: A frame is 9 rows of 90 bytes, sent row by row, with in_sof high together with the byte at row 1, column 1. Parity is the bitwise XOR of every accepted byte of a frame except rows 1-3, columns 1-3. That parity is compared with the byte at row 5, column 1 (B2) of the next frame, and the B2 byte itself counts in the parity of its own frame.
- R2: With count_blocks low, each checked B2 byte adds to the running count the number of set bits (0 to 8) in B2 XOR the reference parity.
- R3: With count_blocks high, each checked B2 byte that differs from the reference parity in any bit adds exactly one to the running count.
- R4: err_pulse is high for exactly the one cycle after a checked B2 byte that differs from the reference parity, and low otherwise.
- R5: On pm_latch, hold_count takes the running count, and the running count restarts from zero. hold_count changes at no other time.
- R6: Errors found in the same cycle as pm_latch go into the new interval: the count after that cycle equals their increment, and hold_count excludes them.
- R7: When an increment would pass 2^CNT_W-1, the count stays at 2^CNT_W-1 if saturate is high. If saturate is low, the count wraps modulo 2^CNT_W.
- R8: While oof is high, no check is made and err_pulse stays low. After oof falls, bytes are ignored until an accepted in_sof, and the first frame after that is not checked because no reference parity exists yet.
- R9: Cycles with in_vld low are ignored. Their data affects neither the parity nor the byte position.
- R10: After reset, hold_count is 0, err_pulse is 0, and the first frame received is not checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Byte strobe; in_byte is taken only when high |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_byte | input | 8 | Descrambled received byte |
| oof | input | 1 | Framer out-of-frame indication |
| pm_latch | input | 1 | Copy the count to the holding register and restart it |
| count_blocks | input | 1 | 1: one per bad frame, 0: one per bad bit |
| saturate | input | 1 | 1: stop at maximum, 0: wrap |
| hold_count | output | CNT_W (18) | Count captured at the last pm_latch |
| err_pulse | output | 1 | One-cycle flag for a failed B2 check |

## Verification
Wrong position tracking or wrong parity accumulation shows up as mismatches on frames whose B2 was built to be correct. The bench therefore builds error-free frames with garbage in the section overhead and in idle cycles. A stray count then appears on err_pulse one cycle after that frame's B2 byte, and in hold_count at the next pm_latch. A lost or stale reference after loss of frame shows up within two frames as a count on the frame that must go unchecked. Counter faults in overflow or latch handling appear at the first pm_latch after the faulty step.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

    // Default frame geometry (zero-based indices are used inside the block)
    localparam int LBM_ROWS     = 9;
    localparam int LBM_COLS     = 90;
    localparam int LBM_SOH_ROWS = 3;
    localparam int LBM_SOH_COLS = 3;
    localparam int LBM_B2_ROW   = 4;
    localparam int LBM_B2_COL   = 0;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } sync_e;

endpackage

// File: rtl/lbm_position.sv
module lbm_position
    import lbm_pkg::*;
#(
    parameter int ROWS     = LBM_ROWS,
    parameter int COLS     = LBM_COLS,
    parameter int SOH_ROWS = LBM_SOH_ROWS,
    parameter int SOH_COLS = LBM_SOH_COLS,
    parameter int B2_ROW   = LBM_B2_ROW,
    parameter int B2_COL   = LBM_B2_COL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_vld,
    input  logic in_sof,
    input  logic oof,
    output logic take,
    output logic frame_start,
    output logic in_soh,
    output logic at_b2,
    output logic at_last
);

    localparam int RW = $clog2(ROWS);
    localparam int CW = $clog2(COLS);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);
    localparam logic [RW-1:0] SOH_R    = RW'(SOH_ROWS);
    localparam logic [CW-1:0] SOH_C    = CW'(SOH_COLS);
    localparam logic [RW-1:0] B2_R     = RW'(B2_ROW);
    localparam logic [CW-1:0] B2_C     = CW'(B2_COL);

    typedef struct packed {
        sync_e         sync;
        logic [RW-1:0] row;
        logic [CW-1:0] col;
    } pos_t;

    pos_t s_d, s_q;
    logic [RW-1:0] cur_row;
    logic [CW-1:0] cur_col;

    always_comb begin
        s_d     = s_q;
        take    = in_vld && !oof && (in_sof || (s_q.sync == ST_LOCK));
        cur_row = in_sof ? '0 : s_q.row;
        cur_col = in_sof ? '0 : s_q.col;

        if (oof) begin
            s_d.sync = ST_HUNT;
            s_d.row  = '0;
            s_d.col  = '0;
        end else if (take) begin
            s_d.sync = ST_LOCK;
            if (cur_col == LAST_COL) begin
                s_d.col = '0;
                s_d.row = (cur_row == LAST_ROW) ? '0 : cur_row + 1'b1;
            end else begin
                s_d.col = cur_col + 1'b1;
                s_d.row = cur_row;
            end
        end

        frame_start = (cur_row == '0) && (cur_col == '0);
        in_soh      = (cur_row < SOH_R) && (cur_col < SOH_C);
        at_b2       = (cur_row == B2_R) && (cur_col == B2_C);
        at_last     = (cur_row == LAST_ROW) && (cur_col == LAST_COL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.col <= LAST_COL) && (s_q.row <= LAST_ROW)); // R1

    AST_HUNT_ON_OOF: assert property (@(posedge clk) disable iff (!rst_n)
        oof |=> (s_q.sync == ST_HUNT)); // R8

endmodule

// File: rtl/lbm_parity.sv
module lbm_parity #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          oof,
    input  logic          take,
    input  logic          frame_start,
    input  logic          in_soh,
    input  logic          at_b2,
    input  logic          at_last,
    input  logic [DW-1:0] in_byte,
    output logic [DW-1:0] mism,
    output logic          err_pulse
);

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] ref_par;
        logic          ref_vld;
        logic          err;
    } par_t;

    par_t s_d, s_q;
    logic [DW-1:0] base;
    logic [DW-1:0] folded;
    logic          do_cmp;

    always_comb begin
        s_d    = s_q;
        base   = frame_start ? '0 : s_q.acc;
        folded = in_soh ? base : (base ^ in_byte);
        do_cmp = take && at_b2 && s_q.ref_vld && !oof;
        mism   = do_cmp ? (in_byte ^ s_q.ref_par) : '0;

        if (oof) begin
            s_d.acc     = '0;
            s_d.ref_vld = 1'b0;
        end else if (take) begin
            if (at_last) begin
                s_d.ref_par = folded;
                s_d.ref_vld = 1'b1;
                s_d.acc     = '0;
            end else begin
                s_d.acc = folded;
            end
        end
        s_d.err = |mism;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign err_pulse = s_q.err;

    AST_NO_ERR_OOF: assert property (@(posedge clk) disable iff (!rst_n)
        oof |=> !err_pulse); // R8

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse); // R4

endmodule

// File: rtl/lbm_counter.sv
module lbm_counter #(
    parameter int CNT_W = 18,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    mism,
    input  logic             count_blocks,
    input  logic             saturate,
    input  logic             pm_latch,
    output logic [CNT_W-1:0] hold_count
);

    localparam int IW = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
    } cnt_t;

    cnt_t s_d, s_q;
    logic [IW-1:0]  ones;
    logic [IW-1:0]  incr;
    logic [CNT_W:0] sum;

    always_comb begin
        ones = '0;
        for (int i = 0; i < DW; i++) begin
            ones = ones + IW'(mism[i]);
        end
        incr = count_blocks ? IW'(|mism) : ones;
        sum  = {1'b0, s_q.cnt} + (CNT_W + 1)'(incr);

        s_d = s_q;
        if (pm_latch) begin
            s_d.hold = s_q.cnt;
            s_d.cnt  = CNT_W'(incr);
        end else if (sum[CNT_W]) begin
            s_d.cnt = saturate ? CNT_MAX : sum[CNT_W-1:0];
        end else begin
            s_d.cnt = sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hold_count = s_q.hold;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pm_latch |=> $stable(hold_count)); // R5

    AST_CLEAR_ON_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        pm_latch |=> (s_q.cnt <= CNT_W'(DW))); // R6

    AST_SAT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (saturate && !pm_latch) |=> (s_q.cnt >= $past(s_q.cnt))); // R7

    AST_BLK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_blocks && !pm_latch && (s_q.cnt != CNT_MAX)) |=>
        ((s_q.cnt == $past(s_q.cnt)) || (s_q.cnt == $past(s_q.cnt) + 1'b1))); // R3

endmodule

// File: rtl/line_bip_monitor.sv
module line_bip_monitor
    import lbm_pkg::*;
#(
    parameter int ROWS     = LBM_ROWS,
    parameter int COLS     = LBM_COLS,
    parameter int SOH_ROWS = LBM_SOH_ROWS,
    parameter int SOH_COLS = LBM_SOH_COLS,
    parameter int B2_ROW   = LBM_B2_ROW,
    parameter int B2_COL   = LBM_B2_COL,
    parameter int DW       = 8,
    parameter int CNT_W    = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic             in_sof,
    input  logic [DW-1:0]    in_byte,
    input  logic             oof,
    input  logic             pm_latch,
    input  logic             count_blocks,
    input  logic             saturate,
    output logic [CNT_W-1:0] hold_count,
    output logic             err_pulse
);

    logic          take;
    logic          frame_start;
    logic          in_soh;
    logic          at_b2;
    logic          at_last;
    logic [DW-1:0] mism;

    lbm_position #(
        .ROWS(ROWS), .COLS(COLS), .SOH_ROWS(SOH_ROWS), .SOH_COLS(SOH_COLS),
        .B2_ROW(B2_ROW), .B2_COL(B2_COL)
    ) i_position (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sof(in_sof), .oof(oof),
        .take(take), .frame_start(frame_start), .in_soh(in_soh),
        .at_b2(at_b2), .at_last(at_last)
    );

    lbm_parity #(.DW(DW)) i_parity (
        .clk(clk), .rst_n(rst_n), .oof(oof), .take(take),
        .frame_start(frame_start), .in_soh(in_soh), .at_b2(at_b2),
        .at_last(at_last), .in_byte(in_byte), .mism(mism), .err_pulse(err_pulse)
    );

    lbm_counter #(.CNT_W(CNT_W), .DW(DW)) i_counter (
        .clk(clk), .rst_n(rst_n), .mism(mism), .count_blocks(count_blocks),
        .saturate(saturate), .pm_latch(pm_latch), .hold_count(hold_count)
    );

endmodule

// File: tb/test_line_bip_monitor.sv
`timescale 1ns/1ps
module test_line_bip_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic        in_sof = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        oof = 1'b0;
    logic        pm_latch = 1'b0;
    logic        count_blocks = 1'b0;
    logic        saturate = 1'b0;
    logic [17:0] hold_count;
    logic        err_pulse;
    logic [3:0]  hold_small;
    logic        err_small;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [7:0]  prev_par = 8'h00;
    bit          prev_known = 1'b0;
    int unsigned exp_cnt = 0;
    int unsigned exp_s = 0;
    int unsigned fidx = 0;

    always #2.5 clk = ~clk;

    line_bip_monitor i_line_bip_monitor (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sof(in_sof),
        .in_byte(in_byte), .oof(oof), .pm_latch(pm_latch),
        .count_blocks(count_blocks), .saturate(saturate),
        .hold_count(hold_count), .err_pulse(err_pulse)
    );

    line_bip_monitor #(.CNT_W(4)) i_line_bip_monitor_small (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sof(in_sof),
        .in_byte(in_byte), .oof(oof), .pm_latch(pm_latch),
        .count_blocks(count_blocks), .saturate(saturate),
        .hold_count(hold_small), .err_pulse(err_small)
    );

    task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    function automatic int unsigned apply(input int unsigned c, input int unsigned inc,
                                          input bit sat, input int w);
        int unsigned mx = (1 << w) - 1;
        int unsigned s = c + inc;
        if (s > mx) return sat ? mx : (s & mx);
        return s;
    endfunction

    task automatic model_b2(input logic [7:0] emask, input bit latch);
        logic [7:0]  m = prev_known ? emask : 8'h00;
        int unsigned inc = count_blocks ? int'(m != 0) : $countones(m);
        chk("R4 err_pulse after B2", err_pulse, int'(m != 0));
        if (latch) begin
            chk("R6 hold excludes coincident errors", hold_count, exp_cnt);
            chk("R6 small hold excludes coincident errors", hold_small, exp_s);
            exp_cnt = inc;
            exp_s   = inc;
        end else begin
            exp_cnt = apply(exp_cnt, inc, saturate, 18);
            exp_s   = apply(exp_s, inc, saturate, 4);
        end
    endtask

    task automatic send_frame(input logic [7:0] emask, input bit latch_b2, input bit gap);
        logic [7:0] par = 8'h00;
        logic [7:0] d;
        for (int r = 0; r < 9; r++) begin
            for (int c = 0; c < 90; c++) begin
                if (gap && (c == 40 || c == 41)) begin
                    in_vld = 1'b0; in_sof = 1'b0; in_byte = 8'hC3;
                    cyc();
                end
                if (r == 4 && c == 0) d = prev_par ^ emask;
                else                  d = 8'(r * 31 + c * 7 + int'(fidx) * 13 + 1);
                in_vld   = 1'b1;
                in_sof   = (r == 0 && c == 0);
                in_byte  = d;
                pm_latch = latch_b2 && (r == 4 && c == 0);
                cyc();
                pm_latch = 1'b0;
                if (!(r < 3 && c < 3)) par ^= d;
                if (r == 4 && c == 0) model_b2(emask, latch_b2);
                if (r == 4 && c == 1) chk("R4 pulse lasts one cycle", err_pulse, 0);
            end
        end
        in_vld = 1'b0; in_sof = 1'b0;
        cyc();
        prev_par   = par;
        prev_known = 1'b1;
        fidx++;
    endtask

    task automatic latch_check(input string tag);
        pm_latch = 1'b1;
        cyc();
        pm_latch = 1'b0;
        chk(tag, hold_count, exp_cnt);
        chk({tag, " (4-bit)"}, hold_small, exp_s);
        exp_cnt = 0;
        exp_s   = 0;
    endtask

    task automatic test_reset();
        chk("R10 hold_count in reset", hold_count, 0);
        chk("R10 err_pulse in reset", err_pulse, 0);
        rst_n = 1'b1;
        cyc();
        chk("R10 hold_count after reset", hold_count, 0);
        send_frame(8'hFF, 1'b0, 1'b0);
        latch_check("R10 first frame unchecked");
    endtask

    task automatic test_bit_mode();
        count_blocks = 1'b0;
        send_frame(8'h00, 1'b0, 1'b0);
        send_frame(8'h01, 1'b0, 1'b0);
        send_frame(8'h81, 1'b0, 1'b0);
        send_frame(8'hFF, 1'b0, 1'b0);
        chk("R2 model total", exp_cnt, 11);
        latch_check("R1 R2 bit-mode total");
    endtask

    task automatic test_block_mode();
        count_blocks = 1'b1;
        send_frame(8'hFF, 1'b0, 1'b0);
        send_frame(8'h10, 1'b0, 1'b0);
        send_frame(8'h00, 1'b0, 1'b0);
        latch_check("R3 block-mode total");
        count_blocks = 1'b0;
    endtask

    task automatic test_gaps();
        send_frame(8'h00, 1'b0, 1'b1);
        send_frame(8'h06, 1'b0, 1'b1);
        latch_check("R9 idle cycles ignored");
    endtask

    task automatic test_latch_same_cycle();
        send_frame(8'h03, 1'b0, 1'b0);
        send_frame(8'h0F, 1'b1, 1'b0);
        latch_check("R5 R6 count after coincident latch");
    endtask

    task automatic test_oof();
        in_vld = 1'b1;
        for (int i = 0; i < 180; i++) begin
            in_sof  = (i == 0);
            in_byte = 8'(i * 5 + 3);
            cyc();
        end
        in_sof = 1'b0;
        oof    = 1'b1;
        for (int i = 0; i < 20; i++) begin
            in_byte = 8'hFF;
            cyc();
            chk("R8 no pulse while out of frame", err_pulse, 0);
        end
        oof        = 1'b0;
        prev_known = 1'b0;
        for (int i = 0; i < 30; i++) begin
            in_byte = 8'(i * 9);
            cyc();
        end
        in_vld = 1'b0;
        cyc();
        send_frame(8'hFF, 1'b0, 1'b0);
        send_frame(8'h01, 1'b0, 1'b0);
        latch_check("R8 resync skips first frame");
    endtask

    task automatic test_saturate();
        saturate = 1'b1;
        send_frame(8'hFF, 1'b0, 1'b0);
        send_frame(8'hFF, 1'b0, 1'b0);
        send_frame(8'h03, 1'b0, 1'b0);
        chk("R7 model saturate", exp_s, 15);
        latch_check("R7 saturate");
    endtask

    task automatic test_rollover();
        saturate = 1'b0;
        send_frame(8'hFF, 1'b0, 1'b0);
        send_frame(8'hFF, 1'b0, 1'b0);
        send_frame(8'h03, 1'b0, 1'b0);
        chk("R7 model rollover", exp_s, 2);
        latch_check("R7 rollover");
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) cyc();
        test_reset();
        test_bit_mode();
        test_block_mode();
        test_gaps();
        test_latch_same_cycle();
        test_oof();
        test_saturate();
        test_rollover();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule